// File: doc/BRIEF.md
# Differential Divide-by-3 Fifty-Percent Duty Divider

This block divides a differential input clock by three and delivers a complementary output pair whose high time is exactly one and a half input periods. Two identical three-state rings run side by side. One steps on every rising edge of the true clock and the other on every rising edge of the complementary clock. Each ring is made of two flip-flops plus a decoded idle phase, so each ring gives three taps that are each high one period in three. The six taps, interleaved half an input period apart, are combined in pairs by OR gates to form the outputs.

Because every output transition is launched by a rising edge of one of the two clock polarities, the output duty cycle and the differential phase do not depend on the duty cycle of the input clock. The relative start of the two rings is not fixed by the global reset. A separate synchronous realign input holds the complementary ring in its idle phase, so that an external corrector can shift that ring until the correct interleave is reached. All six taps are brought out so that the phase order can be observed.

Top module: `diff_div3_top`

## Requirements
- R1: While `rstN` is low both rings sit in their idle phase: taps = 6'b100100 (bit 2 and bit 5 high), `outP` = 0 and `outN` = 0. Tap bit order is taps[0..5] = A, B, C, D, E, F.
- R2: The true-clock ring steps C -> A -> B -> C on each rising edge of `clkP`, and exactly one of A, B, C is high at any time.
- R3: The complementary-clock ring steps F -> D -> E -> F on each rising edge of `clkN`, and exactly one of D, E, F is high at any time.
- R4: `outP` equals A OR E, and `outN` equals B OR D.
- R5: When `realign` is high at a rising edge of `clkN`, the complementary ring goes to its idle phase F (D = E = 0) at that edge. The true-clock ring is not affected.
- R6: When D rises 1.5 input periods after A, the taps repeat every 3 periods in the half-period order A+E, A+F, B+F, B+D, C+D, C+E. `outP` is then high for 3 half-periods out of 6 and `outN` is its complement at every half-period.
- R7: If both rings leave reset together with `realign` low, D rises half a period before A. The outputs are then not complementary, and `outP` and `outN` are both high while A and D overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkP | input | 1 | True input clock; steps the A/B/C ring on its rising edge |
| clkN | input | 1 | Complementary input clock; steps the D/E/F ring on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset for both rings |
| realign | input | 1 | Synchronous (on `clkN`) hold of the D/E/F ring in its idle phase |
| outP | output | 1 | True divided output, A OR E |
| outN | output | 1 | Complementary divided output, B OR D |
| taps | output | 6 | Ring phases, bit 0 = A up to bit 5 = F |

## Verification
The main function is tried with three start-up patterns. In the first, realign is held for two clkN edges after reset, which gives the correct 1.5-period offset. In the second, both rings are released together, which gives the wrong offset with overlapping outputs. In the third, realign is pulsed in steady state. The aligned pattern is checked at each half-period over several output periods against the six-entry phase table, so that a wrong ring order, a wrong OR pairing or a wrong clock edge each produce a table mismatch. The misaligned start shows that the outputs depend on the ring offset. The steady-state pulse shows that the hold acts only on the complementary ring and that the true ring keeps stepping through it.

// File: rtl/div3_pkg.sv
`timescale 1ns/1ps
package div3_pkg;
  localparam int PHASE_CNT = 3;
  localparam int RING_CNT  = 2;
  localparam int TAP_CNT   = PHASE_CNT * RING_CNT;

  typedef struct packed {
    logic clear;
    logic advance;
  } ringStrobeT;
endpackage

// File: rtl/div3_ring_ctrl.sv
`timescale 1ns/1ps
module div3_ring_ctrl
  import div3_pkg::*;
(
  input  logic       holdReq,
  output ringStrobeT strobe
);
  // Hold has priority; otherwise the ring steps on every edge.
  always_comb begin
    strobe.clear   = holdReq;
    strobe.advance = ~holdReq;
  end
endmodule

// File: rtl/div3_ring_dp.sv
`timescale 1ns/1ps
module div3_ring_dp
  import div3_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ringStrobeT           strobe,
  output logic [PHASE_CNT-1:0] phase
);
  logic lead;
  logic trail;
  logic idle;

  assign idle = ~lead & ~trail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lead  <= 1'b0;
      trail <= 1'b0;
    end else if (strobe.clear) begin
      lead  <= 1'b0;
      trail <= 1'b0;
    end else if (strobe.advance) begin
      lead  <= idle;
      trail <= lead;
    end
  end

  // phase[0] = first active, phase[1] = second active, phase[2] = idle
  assign phase = {idle, trail, lead};

  // R2 / R3: one phase active at a time
  a_r2_single_phase: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({idle, trail, lead}));

  // R2 / R3: ring order lead -> trail -> idle
  a_r2_lead_to_trail: assert property (@(posedge clk) disable iff (!rstN)
    (lead && !strobe.clear) |=> (trail && !lead));

  a_r3_trail_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (trail && !strobe.clear) |=> (!lead && !trail));

  // R5: a hold forces the idle phase on the next edge
  a_r5_clear_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (!lead && !trail));
endmodule

// File: rtl/diff_div3_top.sv
`timescale 1ns/1ps
module diff_div3_top
  import div3_pkg::*;
(
  input  logic               clkP,
  input  logic               clkN,
  input  logic               rstN,
  input  logic               realign,
  output logic               outP,
  output logic               outN,
  output logic [TAP_CNT-1:0] taps
);
  for (genvar pol = 0; pol < RING_CNT; pol++) begin : g_ring
    logic                 ringClk;
    logic                 holdReq;
    ringStrobeT           strobe;
    logic [PHASE_CNT-1:0] phase;

    if (pol == 0) begin : g_true
      assign ringClk = clkP;
      assign holdReq = 1'b0;
    end else begin : g_comp
      assign ringClk = clkN;
      assign holdReq = realign;
    end

    div3_ring_ctrl ctrl_i (
      .holdReq (holdReq),
      .strobe  (strobe)
    );

    div3_ring_dp dp_i (
      .clk    (ringClk),
      .rstN   (rstN),
      .strobe (strobe),
      .phase  (phase)
    );

    assign taps[pol*PHASE_CNT +: PHASE_CNT] = phase;
  end

  // R4: cross pairing of taps, A|E and B|D
  assign outP = taps[0] | taps[4];
  assign outN = taps[1] | taps[3];

  // R5: the true ring keeps stepping while the complementary ring is held
  a_r5_true_ring_free: assert property (@(posedge clkP) disable iff (!rstN)
    taps[0] |=> taps[1]);
endmodule

// File: tb/diff_div3_top_tb_top.sv
`timescale 1ns/1ps
module diff_div3_top_tb_top;
  logic       clkP = 1'b0;
  logic       clkN;
  logic       rstN = 1'b0;
  logic       realign = 1'b1;
  logic       outP;
  logic       outN;
  logic [5:0] taps;
  int         checks = 0;
  int         errors = 0;

  assign clkN = ~clkP;
  always #2.5 clkP = ~clkP;

  diff_div3_top dut_i (
    .clkP(clkP), .clkN(clkN), .rstN(rstN), .realign(realign),
    .outP(outP), .outN(outN), .taps(taps)
  );

  // {outP, outN, taps[5:0]} per half-period once aligned (R6)
  localparam logic [7:0] SEQ [6] = '{
    8'b10_010001, 8'b10_100001, 8'b01_100010,
    8'b01_001010, 8'b01_001100, 8'b10_010100
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic align_start();
    rstN    = 1'b0;
    realign = 1'b1;
    @(posedge clkP); #1.25;
    rstN = 1'b1;
    @(posedge clkP);
    @(posedge clkP); #1.25;
    realign = 1'b0;
    @(posedge clkP);
    @(posedge clkP); #1.25;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    #6.25;
    check("R1 reset state", {outP, outN, taps}, 8'b00_100100);

    // R2 R3 R4 R6: aligned start, walk the phase table
    align_start();
    for (int rep = 0; rep < 4; rep++) begin
      for (int h = 0; h < 6; h++) begin
        check("R6 aligned sequence", {outP, outN, taps}, SEQ[h]);
        if (h < 5) #2.5;
      end
      if (rep < 3) #2.5;
    end

    // R5: realign in steady state (now in C+E half-period)
    realign = 1'b1;
    #2.5;
    check("R5 true ring unaffected", {outP, outN, taps}, 8'b10_010001);
    #2.5;
    check("R5 hold forces F", {outP, outN, taps}, 8'b10_100001);
    #2.5;
    check("R5 true ring steps to B", {outP, outN, taps}, 8'b01_100010);
    #2.5;
    check("R5 D held off", {outP, outN, taps}, 8'b01_100010);
    realign = 1'b0;

    // R1: asynchronous reset in mid-run
    #1.0;
    rstN = 1'b0;
    #0.5;
    check("R1 async reset", {outP, outN, taps}, 8'b00_100100);

    // R7: both rings released together
    @(posedge clkP); #1.25;
    realign = 1'b0;
    rstN = 1'b1;
    #2.5;
    check("R7 D leads", {outP, outN, taps}, 8'b01_001100);
    #2.5;
    check("R7 outputs overlap", {outP, outN, taps}, 8'b11_001001);

    // R6 again after re-alignment
    align_start();
    for (int h = 0; h < 6; h++) begin
      check("R6 realigned", {outP, outN, taps}, SEQ[h]);
      #2.5;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule